// File: doc/BRIEF.md
# Peripheral Bus Clock Divider

This block derives a peripheral bus clock from its parent clock by an integer ratio that software picks through one 16-bit control word. The word holds a 7-bit ratio field, a gate bit that turns the output on or off, and a status flag that software reads to learn whether a ratio change has landed. A write takes effect in the control word at once. The counter that shapes the output keeps the old ratio until the current output period ends, and only then switches. This means the bus clock never carries a clipped high or low phase because of a rate change.

Software writes the new ratio and then polls the status flag until it reads back high. After that, the output runs at the new rate. Clearing the gate bit stops the output in the low state. Setting the bit again starts the output with a complete low phase.

Top module: `pbclk_divider`

## Requirements
- R1: The output period is N = field + 1 parent cycles, so the range is 1 to 128. For N ≥ 2 the output is high for floor(N/2) cycles and low for ceil(N/2) cycles, with the low phase first. For N = 1 the output follows the parent clock.
- R2: The control word has the ratio field in bits 6:0, the ready flag in bit 11 and the gate enable in bit 15. All other bits read as zero. A write to bit 11 has no effect on it.
- R3: A write whose ratio field differs from the stored field drives the ready flag low from the next clock edge.
- R4: A new ratio takes effect only at the end of the output period in progress. The old period, including its high phase, completes unchanged. Ready rises at the edge where the new ratio is loaded.
- R5: Once a change is pending, ready is high again within two output periods of the old ratio. With the gate off, this happens one cycle after the write.
- R6: Reading the ratio field after ready has risen returns the value that was written.
- R7: While the gate bit is low, the output stays low. When the gate bit is cleared during a high phase, the output drops at the next edge (N ≥ 2) or after the current parent pulse (N = 1).
- R8: Setting the gate bit starts a fresh period. The output is low for exactly ceil(N/2) parent cycles, counted from the write edge, before its first rise.
- R9: A write that repeats the stored ratio field leaves ready high.
- R10: After reset the control word reads 16'h0800 (field 0, gate off, ready high) and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 16 | Control word write data |
| rd_data_o | output | 16 | Control word read data |
| clk_o | output | 1 | Divided bus clock |

## Verification
The control word and the ready flag change at the clock edge that captures a write. They are sampled half a cycle later. After a ratio change, ready rises at the period boundary: one edge later with the gate off, and up to N_old edges later with the gate on. The phase test writes just after an output rise on a ratio of 8 and expects exactly three more cycles of high output with ready low before both change. Output shape is measured in half-cycle samples taken 1 ns after each parent edge. A monitor aligns to a rising edge and compares every high and low run against queued values of 2·floor(N/2) and 2·ceil(N/2), or 1 and 1 for N = 1. The queue is filled only once ready is high, so every measured period belongs to the new ratio.

// File: rtl/pbdiv_pkg.sv
package pbdiv_pkg;

    localparam int PB_DIV_W   = 7;
    localparam int PB_REG_W   = 16;
    localparam int PB_RDY_POS = 11;
    localparam int PB_EN_POS  = 15;

    typedef logic [PB_DIV_W-1:0] pb_field_t;

    typedef struct packed {
        logic      en;
        pb_field_t div;
    } pb_ctl_t;

    // Number of low cycles in one output period: ceil((field+1)/2).
    function automatic pb_field_t pb_low_len(input pb_field_t f);
        logic [PB_DIV_W:0] s;
        s = {1'b0, f} + (PB_DIV_W+1)'(2);
        return s[PB_DIV_W:1];
    endfunction

    function automatic logic [PB_REG_W-1:0] pb_read_word(input pb_ctl_t c, input logic rdy);
        logic [PB_REG_W-1:0] w;
        w                 = '0;
        w[PB_DIV_W-1:0]   = c.div;
        w[PB_RDY_POS]     = rdy;
        w[PB_EN_POS]      = c.en;
        return w;
    endfunction

endpackage

// File: rtl/pbdiv_regs.sv
module pbdiv_regs
    import pbdiv_pkg::*;
#(
    parameter int REG_W   = PB_REG_W,
    parameter int RDY_POS = PB_RDY_POS,
    parameter int EN_POS  = PB_EN_POS
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             load_i,
    output pb_ctl_t          ctl_o,
    output logic             en_next_o,
    output logic             pend_o,
    output logic [REG_W-1:0] rd_data_o
);

    pb_ctl_t   ctl_q;
    logic      pend_q;
    pb_field_t wr_field;
    logic      wr_changes;
    logic      unused_wr;

    assign wr_field   = wr_data_i[PB_DIV_W-1:0];
    assign wr_changes = wr_en_i && (wr_field != ctl_q.div);
    assign unused_wr  = ^wr_data_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (load_i) begin
                pend_q <= 1'b0;
            end
            if (wr_en_i) begin
                ctl_q.div <= wr_field;
                ctl_q.en  <= wr_data_i[EN_POS];
            end
            if (wr_changes) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign ctl_o     = ctl_q;
    assign pend_o    = pend_q;
    assign en_next_o = wr_en_i ? wr_data_i[EN_POS] : ctl_q.en;
    assign rd_data_o = pb_read_word(ctl_q, !pend_q);

    // A write that changes the field makes the change pending.
    assert_pend_set_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_changes |=> pend_q);

    // A write that repeats the field never raises a new pending change.
    assert_same_keeps_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && !wr_changes && !pend_q) |=> !pend_q);

endmodule

// File: rtl/pbdiv_counter.sv
module pbdiv_counter
    import pbdiv_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      en_i,
    input  logic      en_next_i,
    input  logic      pend_i,
    input  pb_field_t prog_div_i,
    output logic      load_o,
    output pb_field_t act_div_o,
    output logic      hi_o
);

    pb_field_t cnt_q;
    pb_field_t act_q;
    logic      hi_q;

    pb_field_t cnt_n;
    pb_field_t act_n;
    logic      hi_n;
    logic      boundary;

    always_comb begin
        boundary = !en_i || (cnt_q == act_q);
        load_o   = boundary && pend_i;
        act_n    = load_o ? prog_div_i : act_q;
        cnt_n    = boundary ? '0 : cnt_q + 1'b1;
        hi_n     = en_next_i && (act_n != '0) && (cnt_n >= pb_low_len(act_n));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            act_q <= '0;
            hi_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            act_q <= act_n;
            hi_q  <= hi_n;
        end
    end

    assign act_div_o = act_q;
    assign hi_o      = hi_q;

    // The active ratio only moves at a period end or while gated.
    assert_load_at_end_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(act_q) |-> ($past(cnt_q) == $past(act_q) || !$past(en_i)));

    // The phase counter never runs past the active ratio.
    assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= act_q);

    // A fresh period after gating opens with the low phase.
    assert_restart_low_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(en_i) |-> !hi_q);

endmodule

// File: rtl/pbdiv_gate.sv
module pbdiv_gate
    import pbdiv_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      en_i,
    input  pb_field_t act_div_i,
    input  logic      hi_i,
    output logic      clk_o
);

    logic pass_q;

    // Pass-through enable is retimed on the falling edge so that the
    // parent clock is only ever gated while it is low.
    always_ff @(negedge clk_i) begin
        if (rst_i) begin
            pass_q <= 1'b0;
        end else begin
            pass_q <= en_i && (act_div_i == '0);
        end
    end

    assign clk_o = hi_i | (clk_i & pass_q);

endmodule

// File: rtl/pbclk_divider.sv
module pbclk_divider
    import pbdiv_pkg::*;
#(
    parameter int REG_W   = PB_REG_W,
    parameter int RDY_POS = PB_RDY_POS,
    parameter int EN_POS  = PB_EN_POS
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             clk_o
);

    pb_ctl_t   ctl;
    logic      en_next;
    logic      pend;
    logic      load;
    pb_field_t act_div;
    logic      hi;

    pbdiv_regs #(
        .REG_W   (REG_W),
        .RDY_POS (RDY_POS),
        .EN_POS  (EN_POS)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .load_i    (load),
        .ctl_o     (ctl),
        .en_next_o (en_next),
        .pend_o    (pend),
        .rd_data_o (rd_data_o)
    );

    pbdiv_counter u_cnt (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .en_i       (ctl.en),
        .en_next_i  (en_next),
        .pend_i     (pend),
        .prog_div_i (ctl.div),
        .load_o     (load),
        .act_div_o  (act_div),
        .hi_o       (hi)
    );

    pbdiv_gate u_gate (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .en_i      (ctl.en),
        .act_div_i (act_div),
        .hi_i      (hi),
        .clk_o     (clk_o)
    );

    // Ready observed at the port falls after a changing write.
    assert_ready_falls_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_data_i[PB_DIV_W-1:0] != rd_data_o[PB_DIV_W-1:0]) |=> !rd_data_o[RDY_POS]);

    // When ready returns, the loaded ratio matches the programmed field.
    assert_ready_loaded_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(rd_data_o[RDY_POS]) |-> (act_div == rd_data_o[PB_DIV_W-1:0] || wr_en_i));

    // With the gate bit low the shaped output stays low.
    assert_gated_low_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !ctl.en |-> !hi);

endmodule

// File: tb/sim_pbclk_divider.sv
`timescale 1ns/1ps
module sim_pbclk_divider;

    typedef struct {
        int    hi;
        int    lo;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        clk_o;

    int   n_vec = 0;
    int   n_bad = 0;
    int   cur_field = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    pbclk_divider u0 (
        .clk_i     (clk),
        .rst_i     (rst),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .clk_o     (clk_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    task automatic take(output bit s);
        @(clk);
        #1;
        s = clk_o;
    endtask

    task automatic push_periods(input int field, input int periods, input string tag);
        exp_t e;
        int   n;
        n = field + 1;
        e.hi  = (n == 1) ? 1 : 2 * (n / 2);
        e.lo  = (n == 1) ? 1 : 2 * ((n + 1) / 2);
        e.tag = tag;
        for (int i = 0; i < periods; i++) exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    // Write the ratio field and gate bit, then wait for ready (R3, R5, R6).
    task automatic program_div(input int field, input bit en, input int nold, input int periods);
        int waited;
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = (en ? 16'h8000 : 16'h0000) | 16'(field);
        @(negedge clk);
        wr_en   = 1'b0;
        if (field != cur_field)
            chk(rd_data[11] == 1'b0, "R3 ready low after changing write", rd_data[11], 0);
        waited = 0;
        while (!rd_data[11]) begin
            waited++;
            @(negedge clk);
        end
        chk(waited <= 2 * nold, "R5 ready back within two periods", waited, 2 * nold);
        chk(rd_data[6:0] == 7'(field), "R6 field readback", rd_data[6:0], field);
        cur_field = field;
        if (en && periods > 0) push_periods(field, periods, "R1 period shape");
    endtask

    // Monitor: aligns to a rising edge, measures runs in half cycles, compares.
    initial begin : monitor
        bit s;
        bit have;
        int h;
        int l;
        have = 1'b0;
        forever begin
            wait (exp_q.size() != 0);
            if (!have) begin
                do take(s); while (s);
                do take(s); while (!s);
            end
            h = 0;
            do begin h++; take(s); end while (s);
            l = 0;
            do begin l++; take(s); end while (!s);
            chk(h == exp_q[0].hi, {exp_q[0].tag, " high halves"}, h, exp_q[0].hi);
            chk(l == exp_q[0].lo, {exp_q[0].tag, " low halves"}, l, exp_q[0].lo);
            void'(exp_q.pop_front());
            have = (exp_q.size() != 0);
        end
    end

    initial begin : watchdog
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin : driver
        bit s;
        bit p;
        int zeros;
        bit low_ok;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        chk(rd_data == 16'h0800, "R10 reset word", rd_data, 16'h0800);
        chk(clk_o == 1'b0, "R10 output low after reset", clk_o, 0);

        // Gate off, change field to 4: ready after one cycle, output low (R7)
        program_div(4, 1'b0, 1, 0);
        low_ok = 1'b1;
        for (int i = 0; i < 40; i++) begin
            take(s);
            if (s) low_ok = 1'b0;
        end
        chk(low_ok, "R7 output held low while gated", low_ok, 1);

        // Enable with the same field: ready stays high (R9), low phase first (R8)
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 16'h8004;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        chk(rd_data[11] == 1'b1, "R9 same-field write keeps ready", rd_data[11], 1);
        zeros = 0;
        s = clk_o;
        while (!s) begin
            zeros++;
            take(s);
        end
        chk(zeros == 6, "R8 restart low halves for N=5", zeros, 6);
        push_periods(4, 3, "R1 period shape N=5");

        // Scoreboard across ratios
        program_div(1,   1'b1, 5,   3);
        program_div(2,   1'b1, 2,   3);
        program_div(7,   1'b1, 3,   3);
        program_div(0,   1'b1, 8,   4);
        program_div(127, 1'b1, 1,   2);
        program_div(7,   1'b1, 128, 2);

        // R4: change just after a rise on N=8, old period completes
        p = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            s = clk_o;
            if (!p && s) break;
            p = s;
        end
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 16'h8002;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(rd_data[11] == 1'b0, "R4 ready low until period end", rd_data[11], 0);
            chk(clk_o == 1'b1, "R4 old high phase kept", clk_o, 1);
            @(posedge clk);
            #1;
        end
        chk(rd_data[11] == 1'b1, "R4 ready at period end", rd_data[11], 1);
        chk(clk_o == 1'b0, "R4 new period starts low", clk_o, 0);
        cur_field = 2;
        push_periods(2, 3, "R4 new ratio N=3");

        // R7: clear the gate while running
        p = 1'b0;
        while (!p) begin
            @(posedge clk);
            #1;
            p = clk_o;
        end
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 16'h0002;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        chk(clk_o == 1'b0, "R7 output drops when gated", clk_o, 0);
        low_ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            take(s);
            if (s) low_ok = 1'b0;
        end
        chk(low_ok, "R7 output stays low after gating", low_ok, 1);

        // R2: junk bits and a set bit 11 are not stored
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 16'h7A05;
        @(negedge clk);
        wr_en = 1'b0;
        chk(rd_data == 16'h0005, "R2 layout with pending change", rd_data, 16'h0005);
        @(negedge clk);
        chk(rd_data == 16'h0805, "R2 layout after load", rd_data, 16'h0805);

        summary();
        $finish;
    end

endmodule